// File: doc/BRIEF.md
# Banked Strided Vector Load Unit

This block turns one vector load request into a stream of word addresses for an interleaved memory. A request carries a base word address, a signed stride in elements and an element count of up to 64. The unit walks the element addresses in index order and sends one request per cycle. The memory has eight banks, and a bank that has just been used must rest before it can take another access. When the next address falls in a bank that is still resting, the unit holds that address back until the bank is free. It never skips ahead to a later element.

The memory returns read data a fixed number of cycles after each request. In the intended system, and in the bench, that number is 12. Responses therefore arrive in request order. The unit tags each returned word with its element index and passes it on. After the last element it raises a one-cycle completion flag and reports the load's length in cycles. That count makes the cost of bank conflicts visible. Unit stride streams one word per cycle. A stride that is a multiple of the bank count hits the same bank every time and is slowed by the full rest time on every element.

Top module: `strided_bank_loader`

## Requirements
- R1: Element i is requested at word address base + i×stride, modulo 2^32, with the stride taken as a two's-complement number. Its bank is the address modulo 8, which is the low three address bits.
- R2: Requests leave in strictly increasing index order, at most one per cycle. Element 0 goes out in the first cycle after the start is accepted, because every bank is free at that point.
- R3: After a request to bank b in cycle t, bank b receives no request in cycles t+1 to t+5. A request waits only while its own bank is resting, and it is issued in the first cycle its bank is free.
- R4: A memory response is presented on the element port in the same cycle it arrives. It carries the next element index, starting at 0 and rising by one per element.
- R5: A load of N ≥ 1 elements raises done for exactly one cycle, the cycle after the last element's data. In that cycle total_cycles equals the number of cycles from the first request through the last data, both included. Stride 1 with 64 elements gives 76.
- R6: A 64-element load whose stride is a multiple of 8, including stride 0, gives a total_cycles of 391.
- R7: A start with length 0 issues no request and raises done in the first cycle after the start, with total_cycles 0.
- R8: A start pulse that arrives while a load is in progress, including its done cycle, is ignored. The running load's requests, elements and total are unchanged.
- R9: After reset, busy, req_valid, elem_valid and done are all 0.
- R10: busy is 1 from the first cycle after an accepted start through the done cycle, and 0 in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a new load; accepted only while busy is 0 |
| base | input | 32 | Word address of element 0 |
| stride | input | 32 | Signed element-to-element address step |
| vlen | input | 7 | Number of elements, 0 to 64 |
| rsp_valid | input | 1 | Memory read data valid |
| rsp_data | input | 32 | Memory read data |
| busy | output | 1 | A load is in progress |
| req_valid | output | 1 | A memory read is requested this cycle |
| req_addr | output | 32 | Word address of the read |
| elem_valid | output | 1 | An element is presented this cycle |
| elem_idx | output | 6 | Index of the presented element |
| elem_data | output | 32 | Data of the presented element |
| done | output | 1 | One-cycle completion pulse |
| total_cycles | output | 16 | Cycle count of the last completed load |

## Verification
The loads use several strides:
- Unit stride shows the stall-free stream of one word per cycle.
- Strides of 8, 32, 0 and -8 send every access to one bank, so the full rest penalty is paid on each element.
- Stride 2 cycles through four banks. This shows a partial stall, where a burst of requests is followed by a gap until the first bank frees.
- Strides of -1 and 3 move through the banks in reverse order or with a skip. They also exercise the two's-complement address wrap.

Lengths of 0 and 1 cover the edge cases of the completion count. A start pulse placed in the middle of a load shows that the running load is left untouched.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } sbl_state_e;
endpackage

// File: rtl/sbl_bank_track.sv
module sbl_bank_track #(
   parameter int NBANK     = 8,
   parameter int BANK_BUSY = 6,
   localparam int BANK_W   = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [BANK_W-1:0] issue_bank,
   output logic [NBANK-1:0]  free_mask
);
   localparam int CNT_W = (BANK_BUSY > 1) ? $clog2(BANK_BUSY) : 1;

   generate
      if (BANK_BUSY > 1) begin : g_timed
         for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic [CNT_W-1:0] rest_q;
            always_ff @(posedge clk) begin
               if (!rst_n) begin
                  rest_q <= '0;
               end else if (issue && issue_bank == BANK_W'(b)) begin
                  rest_q <= CNT_W'(BANK_BUSY - 1);
               end else if (rest_q != '0) begin
                  rest_q <= rest_q - CNT_W'(1);
               end
            end
            assign free_mask[b] = (rest_q == '0);
         end
      end else begin : g_untimed
         logic unused_in;
         assign unused_in = ^{clk, rst_n, issue, issue_bank};
         assign free_mask = '1;
      end
   endgenerate
endmodule

// File: rtl/sbl_addr_gen.sv
module sbl_addr_gen #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] stride_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q   <= '0;
         stride_q <= '0;
      end else if (load) begin
         addr_q   <= base;
         stride_q <= stride;
      end else if (step) begin
         addr_q   <= addr_q + stride_q;
      end
   end

   assign addr = addr_q;
endmodule

// File: rtl/sbl_resp_tag.sv
module sbl_resp_tag #(
   parameter int DATA_W  = 32,
   parameter int MAX_LEN = 64,
   localparam int LEN_W  = $clog2(MAX_LEN + 1),
   localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              enable,
   input  logic [LEN_W-1:0]  len,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              elem_valid,
   output logic [IDX_W-1:0]  elem_idx,
   output logic [DATA_W-1:0] elem_data,
   output logic              last
);
   logic [IDX_W-1:0] rx_q;
   logic             fire;

   assign fire = enable && rsp_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (clear) begin
         rx_q <= '0;
      end else if (fire) begin
         rx_q <= rx_q + IDX_W'(1);
      end
   end

   assign elem_valid = fire;
   assign elem_idx   = rx_q;
   assign elem_data  = rsp_data;
   assign last       = fire && (LEN_W'(rx_q) == len - LEN_W'(1));
endmodule

// File: rtl/strided_bank_loader.sv
module strided_bank_loader
   import sbl_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int NBANK     = 8,
   parameter int BANK_BUSY = 6,
   parameter int MAX_LEN   = 64,
   parameter int CYC_W     = 16,
   localparam int LEN_W    = $clog2(MAX_LEN + 1),
   localparam int IDX_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
   localparam int BANK_W   = $clog2(NBANK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] stride,
   input  logic [LEN_W-1:0]  vlen,
   input  logic              rsp_valid,
   input  logic [DATA_W-1:0] rsp_data,
   output logic              busy,
   output logic              req_valid,
   output logic [ADDR_W-1:0] req_addr,
   output logic              elem_valid,
   output logic [IDX_W-1:0]  elem_idx,
   output logic [DATA_W-1:0] elem_data,
   output logic              done,
   output logic [CYC_W-1:0]  total_cycles
);
   generate
      if (NBANK < 2 || (NBANK & (NBANK - 1)) != 0) begin : g_bad_nbank
         $error("NBANK must be a power of two of at least 2");
      end
      if (BANK_BUSY < 1) begin : g_bad_busy
         $error("BANK_BUSY must be at least 1");
      end
      if (MAX_LEN < 1) begin : g_bad_len
         $error("MAX_LEN must be at least 1");
      end
      if (ADDR_W < BANK_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the bank select");
      end
   endgenerate

   sbl_state_e          state_q;
   logic                accept;
   logic [LEN_W-1:0]    len_q;
   logic [LEN_W-1:0]    iss_q;
   logic [CYC_W-1:0]    cyc_q;
   logic [CYC_W-1:0]    total_q;
   logic [NBANK-1:0]    free_mask;
   logic [ADDR_W-1:0]   cur_addr;
   logic [BANK_W-1:0]   cur_bank;
   logic                issue;
   logic                last_elem;

   assign accept   = start && (state_q == ST_IDLE);
   assign cur_bank = cur_addr[BANK_W-1:0];
   assign issue    = (state_q == ST_RUN) && (iss_q < len_q) && free_mask[cur_bank];

   sbl_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .base   (base),
      .stride (stride),
      .step   (issue),
      .addr   (cur_addr)
   );

   sbl_bank_track #(.NBANK(NBANK), .BANK_BUSY(BANK_BUSY)) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_bank (cur_bank),
      .free_mask  (free_mask)
   );

   sbl_resp_tag #(.DATA_W(DATA_W), .MAX_LEN(MAX_LEN)) u_tag (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (accept),
      .enable     (state_q == ST_RUN),
      .len        (len_q),
      .rsp_valid  (rsp_valid),
      .rsp_data   (rsp_data),
      .elem_valid (elem_valid),
      .elem_idx   (elem_idx),
      .elem_data  (elem_data),
      .last       (last_elem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         len_q   <= '0;
         iss_q   <= '0;
         cyc_q   <= '0;
         total_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  len_q   <= vlen;
                  iss_q   <= '0;
                  cyc_q   <= '0;
                  total_q <= '0;
                  state_q <= (vlen == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               cyc_q <= cyc_q + CYC_W'(1);
               if (issue) begin
                  iss_q <= iss_q + LEN_W'(1);
               end
               if (last_elem) begin
                  total_q <= cyc_q + CYC_W'(1);
                  state_q <= ST_FIN;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign busy         = (state_q != ST_IDLE);
   assign req_valid    = issue;
   assign req_addr     = cur_addr;
   assign done         = (state_q == ST_FIN);
   assign total_cycles = total_q;
endmodule

// File: rtl/sbl_checker.sv
module sbl_checker #(
   parameter int ADDR_W    = 32,
   parameter int NBANK     = 8,
   parameter int BANK_BUSY = 6,
   parameter int IDX_W     = 6,
   localparam int BANK_W   = $clog2(NBANK)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] base,
   input logic [ADDR_W-1:0] stride,
   input logic              busy,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              elem_valid,
   input logic [IDX_W-1:0]  elem_idx,
   input logic              done
);
   logic              take;
   logic [ADDR_W-1:0] m_base, m_stride, m_last;
   logic              m_prev;
   logic [IDX_W-1:0]  m_ecnt;

   assign take = start && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_base <= '0; m_stride <= '0; m_last <= '0; m_prev <= 1'b0; m_ecnt <= '0;
      end else begin
         if (take) begin
            m_base <= base; m_stride <= stride; m_prev <= 1'b0; m_ecnt <= '0;
         end else begin
            if (req_valid) begin
               m_last <= req_addr; m_prev <= 1'b1;
            end
            if (elem_valid) m_ecnt <= m_ecnt + IDX_W'(1);
         end
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_rest
      logic [7:0] since;
      always_ff @(posedge clk) begin
         if (!rst_n) since <= 8'(BANK_BUSY);
         else if (req_valid && req_addr[BANK_W-1:0] == BANK_W'(b)) since <= '0;
         else if (since < 8'(BANK_BUSY)) since <= since + 8'd1;
      end
      // R3
      bank_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_valid && req_addr[BANK_W-1:0] == BANK_W'(b)) |-> (since >= 8'(BANK_BUSY - 1)));
   end

   // R1
   first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !m_prev) |-> (req_addr == m_base));
   // R1
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && m_prev) |-> (req_addr == m_last + m_stride));
   // R4
   elem_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid |-> (elem_idx == m_ecnt));
   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   req_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid || elem_valid || done) |-> busy);
   // R10
   idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
endmodule

bind strided_bank_loader sbl_checker #(
   .ADDR_W(ADDR_W), .NBANK(NBANK), .BANK_BUSY(BANK_BUSY), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
   .busy(busy), .req_valid(req_valid), .req_addr(req_addr),
   .elem_valid(elem_valid), .elem_idx(elem_idx), .done(done)
);

// File: tb/strided_bank_loader_bench.sv
`timescale 1ns/1ps
module strided_bank_loader_bench;
   localparam int LAT = 12;
   localparam int RST = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base = '0;
   logic [31:0] stride = '0;
   logic [6:0]  vlen = '0;
   logic        rsp_valid;
   logic [31:0] rsp_data;
   logic        busy, req_valid, elem_valid, done;
   logic [31:0] req_addr, elem_data;
   logic [5:0]  elem_idx;
   logic [15:0] total_cycles;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;

   always #2.5 clk = ~clk;

   strided_bank_loader u_strided_bank_loader (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
      .vlen(vlen), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy),
      .req_valid(req_valid), .req_addr(req_addr), .elem_valid(elem_valid),
      .elem_idx(elem_idx), .elem_data(elem_data), .done(done),
      .total_cycles(total_cycles)
   );

   function automatic logic [31:0] mem_word(input logic [31:0] a);
      return (a * 32'h9E3779B1) ^ 32'h00005A5A;
   endfunction

   // memory model: fixed-latency read pipe
   logic        pv[LAT];
   logic [31:0] pd[LAT];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < LAT; k++) begin pv[k] <= 1'b0; pd[k] <= '0; end
      end else begin
         pv[0] <= req_valid;
         pd[0] <= mem_word(req_addr);
         for (int k = 1; k < LAT; k++) begin pv[k] <= pv[k-1]; pd[k] <= pd[k-1]; end
      end
   end
   assign rsp_valid = pv[LAT-1];
   assign rsp_data  = pd[LAT-1];

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   // Drive one load, compare against a behavioural schedule every cycle.
   // poke >= 0: a foreign start pulse is driven in that cycle (R8).
   task automatic run_load(input logic [31:0] b, input int s, input int n,
                           input int poke, output int total);
      int          t_iss[64];
      logic [31:0] a[64];
      int          free_at[8];
      int          prev;
      logic        e_req, e_el;
      logic [31:0] e_addr, e_data;
      int          e_idx;
      for (int k = 0; k < 8; k++) free_at[k] = 0;
      prev = -1;
      for (int i = 0; i < n; i++) begin
         int bk, t;
         a[i] = b + 32'(i * s);
         bk   = int'(a[i][2:0]);
         t    = prev + 1;
         if (free_at[bk] > t) t = free_at[bk];
         t_iss[i] = t;
         free_at[bk] = t + 6;
         prev = t;
      end
      total = (n == 0) ? 0 : t_iss[n-1] + LAT + 1;

      start = 1'b1; base = b; stride = 32'(s); vlen = 7'(n);
      @(negedge clk);
      for (int c = 0; c <= total; c++) begin
         if (c == poke) begin
            start = 1'b1; base = 32'hDEAD0000; stride = 32'd5; vlen = 7'd2;
         end else begin
            start = 1'b0;
         end
         e_req = 1'b0; e_addr = '0; e_el = 1'b0; e_idx = 0; e_data = '0;
         for (int i = 0; i < n; i++) begin
            if (t_iss[i] == c) begin e_req = 1'b1; e_addr = a[i]; end
            if (t_iss[i] + LAT == c) begin e_el = 1'b1; e_idx = i; e_data = mem_word(a[i]); end
         end
         chk("R10 busy", 64'(busy), 64'd1);
         chk("R2,R3 req_valid", 64'(req_valid), 64'(e_req));
         if (e_req) chk("R1 req_addr", 64'(req_addr), 64'(e_addr));
         chk("R4 elem_valid", 64'(elem_valid), 64'(e_el));
         if (e_el) begin
            chk("R4 elem_idx", 64'(elem_idx), 64'(e_idx));
            chk("R4 elem_data", 64'(elem_data), 64'(e_data));
         end
         chk("R5 done", 64'(done), 64'(c == total));
         if (c == total) chk("R5 total_cycles", 64'(total_cycles), 64'(total));
         @(negedge clk);
      end
      start = 1'b0;
      chk("R10 busy low after done", 64'(busy), 64'd0);
      chk("R5 done low after pulse", 64'(done), 64'd0);
      @(negedge clk);
   endtask

   initial begin
      int tot;
      repeat (RST) @(negedge clk);
      // R9 reset state
      chk("R9 busy", 64'(busy), 64'd0);
      chk("R9 req_valid", 64'(req_valid), 64'd0);
      chk("R9 elem_valid", 64'(elem_valid), 64'd0);
      chk("R9 done", 64'(done), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_load(32'h100, 1, 64, -1, tot);
      chk("R5 unit stride 64 = 76", 64'(tot), 64'd76);
      run_load(32'h0, 32, 64, -1, tot);
      chk("R6 stride 32 = 391", 64'(tot), 64'd391);
      run_load(32'h5, 8, 64, -1, tot);
      chk("R6 stride 8 = 391", 64'(tot), 64'd391);
      run_load(32'h77, 0, 64, -1, tot);
      chk("R6 stride 0 = 391", 64'(tot), 64'd391);
      run_load(32'h10, -8, 8, -1, tot);
      run_load(32'h40, 2, 16, -1, tot);
      run_load(32'h3, -1, 10, -1, tot);
      run_load(32'h0, 0, 0, -1, tot);
      chk("R7 zero length total", 64'(tot), 64'd0);
      run_load(32'h1234, 7, 1, -1, tot);
      chk("R5 single element total", 64'(tot), 64'd13);
      run_load(32'h20, 3, 30, 4, tot);
      run_load(32'h800, 1, 4, 16, tot);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule